// File: doc/BRIEF.md
# Vector Destination Byte Classifier

This combinational block labels each byte of one destination vector register for a single micro-op. It uses the starting element, the active vector length, the element width, the mask-enable bit and the v0 mask. Each byte gets one of four 2-bit codes: leave unchanged, tail, body-inactive or body-active. Retire logic turns these codes into write strobes and fill policies.

A micro-op covers one register of a register group, so the global number of each element depends on the micro-op's position in the group. A half-register mode serves micro-ops whose result fills only half of the destination register, as in widening or narrowing work. In that mode the micro-op index selects which half is written, and the bytes of the other half are left unchanged.

Top module: `vbc_classifier`

## Requirements
- R1: Each byte's 2-bit code sits at bits [2b+1:2b] of the output. The codes are 0 = unchanged, 1 = tail, 2 = body-inactive and 3 = body-active.
- R2: The element width select is 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and 3 = 64-bit. All bytes of one element carry the same code.
- R3: In full mode, the global element number of byte b is uop_index × (VLENB / element bytes) + b / element bytes.
- R4: A byte whose element number is below the start index is coded unchanged. This rule takes priority over the tail rule.
- R5: A byte whose element number is at or above the vector length, and not below the start index, is coded tail. In full mode, no body byte follows a tail byte at a higher position in the register.
- R6: When the mask-enable bit is 1, every body byte is coded body-active.
- R7: When the mask-enable bit is 0, bit n of v0 makes element n active (1) or inactive (0).
- R8: In half mode, the element number uses uop_index / 2 as the group position. Only the half that uop_index bit 0 selects is classified (0 = lower bytes, 1 = upper bytes). Every byte of the other half is coded unchanged.
- R9: When the start index is at or above the vector length, no byte is coded body-active or body-inactive.
- R10: In full mode with a start index of 0, no byte is coded unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vstart_i | input | $clog2(VLEN) | First element index to be processed |
| vl_i | input | $clog2(VLEN)+1 | Active vector length in elements |
| sew_i | input | 2 | Element width select |
| vm_i | input | 1 | Mask enable, 1 = unmasked |
| v0_i | input | VLEN | Mask register contents |
| uop_idx_i | input | UIDX_W | Position of the micro-op within the register group |
| half_i | input | 1 | Half-register mode for widening or narrowing micro-ops |
| byte_class_o | output | 2*VLENB | Packed per-byte class codes |

## Verification
Some properties hold for every input, and the bound checker tests them whenever the inputs are known:
- bytes of one element share a code;
- in full mode no body byte follows a tail byte;
- an unmasked micro-op produces no inactive bytes;
- a start index at or above the vector length leaves no body bytes;
- half mode leaves at least half the register unchanged;
- in full mode a zero start index leaves no byte unchanged.

The exact element numbering across group positions, the lookup of each v0 bit, and which half is chosen in half mode are value-level results. Only the bench's table vectors and its sweep over every width, micro-op index and mode against an independent model can show those.

// File: rtl/vbc_pkg.sv
package vbc_pkg;

   typedef enum logic [1:0] {
      VBC_KEEP  = 2'b00,
      VBC_TAIL  = 2'b01,
      VBC_INACT = 2'b10,
      VBC_ACT   = 2'b11
   } vbc_class_e;

   typedef enum logic [1:0] {
      VBC_EW8  = 2'd0,
      VBC_EW16 = 2'd1,
      VBC_EW32 = 2'd2,
      VBC_EW64 = 2'd3
   } vbc_width_e;

endpackage

// File: rtl/vbc_index_gen.sv
// Per-byte global element number and half-mode exclusion flag.
module vbc_index_gen #(
   parameter int VLENB  = 16,
   parameter int UIDX_W = 3,
   parameter int IDX_W  = 8
) (
   input  logic [1:0]               sew_i,
   input  logic [UIDX_W-1:0]        uidx_i,
   input  logic                     half_i,
   output logic [VLENB-1:0][IDX_W-1:0] idx_o,
   output logic [VLENB-1:0]         spare_o
);
   localparam int LOG_B = $clog2(VLENB);
   localparam int HALF  = VLENB / 2;

   logic [IDX_W-1:0] grp;

   always_comb begin
      if (half_i) grp = IDX_W'(uidx_i >> 1);
      else        grp = IDX_W'(uidx_i);
   end

   for (genvar b = 0; b < VLENB; b++) begin : g_byte
      logic [IDX_W-1:0] loc;
      logic             upper;
      always_comb begin
         loc        = IDX_W'(b) >> sew_i;
         idx_o[b]   = (grp << (LOG_B - int'(sew_i))) + loc;
         upper      = (b >= HALF);
         spare_o[b] = half_i && (upper != uidx_i[0]);
      end
   end
endmodule

// File: rtl/vbc_lane.sv
// Classification of one byte from its element number.
module vbc_lane
   import vbc_pkg::*;
#(
   parameter int IDX_W = 8,
   parameter int VS_W  = 7
) (
   input  logic [IDX_W-1:0] idx_i,
   input  logic             spare_i,
   input  logic [VS_W-1:0]  vstart_i,
   input  logic [IDX_W-1:0] vl_i,
   input  logic             vm_i,
   input  logic             mbit_i,
   output vbc_class_e       cls_o
);
   logic prestart, tail;

   always_comb begin
      prestart = idx_i < IDX_W'(vstart_i);
      tail     = idx_i >= vl_i;
      if (spare_i || prestart) cls_o = VBC_KEEP;
      else if (tail)           cls_o = VBC_TAIL;
      else if (vm_i || mbit_i) cls_o = VBC_ACT;
      else                     cls_o = VBC_INACT;
   end
endmodule

// File: rtl/vbc_classifier.sv
module vbc_classifier
   import vbc_pkg::*;
#(
   parameter int VLEN   = 128,
   parameter int UIDX_W = 3,
   localparam int VLENB = VLEN / 8,
   localparam int VS_W  = $clog2(VLEN),
   localparam int IDX_W = $clog2(VLEN) + 1
) (
   input  logic [VS_W-1:0]    vstart_i,
   input  logic [IDX_W-1:0]   vl_i,
   input  logic [1:0]         sew_i,
   input  logic               vm_i,
   input  logic [VLEN-1:0]    v0_i,
   input  logic [UIDX_W-1:0]  uop_idx_i,
   input  logic               half_i,
   output logic [2*VLENB-1:0] byte_class_o
);
   if (VLEN < 64 || (VLEN & (VLEN - 1)) != 0) begin : g_bad_vlen
      $error("VLEN must be a power of two of at least 64");
   end
   if ((VLENB << UIDX_W) > VLEN) begin : g_bad_uidx
      $error("register group can address elements beyond the mask register");
   end

   logic [VLENB-1:0][IDX_W-1:0] idx;
   logic [VLENB-1:0]            spare;
   logic [VLENB-1:0]            mbit;

   vbc_index_gen #(.VLENB(VLENB), .UIDX_W(UIDX_W), .IDX_W(IDX_W)) u_idx (
      .sew_i   (sew_i),
      .uidx_i  (uop_idx_i),
      .half_i  (half_i),
      .idx_o   (idx),
      .spare_o (spare)
   );

   for (genvar b = 0; b < VLENB; b++) begin : g_lane
      vbc_class_e cls;
      assign mbit[b] = v0_i[idx[b][IDX_W-2:0]];
      vbc_lane #(.IDX_W(IDX_W), .VS_W(VS_W)) u_lane (
         .idx_i    (idx[b]),
         .spare_i  (spare[b]),
         .vstart_i (vstart_i),
         .vl_i     (vl_i),
         .vm_i     (vm_i),
         .mbit_i   (mbit[b]),
         .cls_o    (cls)
      );
      assign byte_class_o[2*b +: 2] = cls;
   end
endmodule

// File: rtl/vbc_classifier_chk.sv
module vbc_classifier_chk #(
   parameter int VLEN   = 128,
   parameter int UIDX_W = 3,
   localparam int VLENB = VLEN / 8,
   localparam int VS_W  = $clog2(VLEN),
   localparam int IDX_W = $clog2(VLEN) + 1
) (
   input logic [VS_W-1:0]    vstart_i,
   input logic [IDX_W-1:0]   vl_i,
   input logic [1:0]         sew_i,
   input logic               vm_i,
   input logic [VLEN-1:0]    v0_i,
   input logic [UIDX_W-1:0]  uop_idx_i,
   input logic               half_i,
   input logic [2*VLENB-1:0] byte_class_o
);
   logic known;
   int   keep_cnt;

   always_comb begin
      known = !$isunknown({vstart_i, vl_i, sew_i, vm_i, v0_i, uop_idx_i, half_i, byte_class_o});
      keep_cnt = 0;
      if (known) begin
         for (int b = 0; b < VLENB; b++) begin
            logic [1:0] c;
            c = byte_class_o[2*b +: 2];
            if (c == 2'b00) keep_cnt++;
            if (b > 0 && (b % (1 << sew_i)) != 0)
               assert_elem_uniform_R2: assert (c == byte_class_o[2*(b-1) +: 2]);
            if (b > 0 && !half_i && byte_class_o[2*(b-1) +: 2] == 2'b01)
               assert_tail_last_R5: assert (c == 2'b01);
            if (vm_i)
               assert_unmasked_active_R6: assert (c != 2'b10);
            if (IDX_W'(vstart_i) >= vl_i)
               assert_empty_body_R9: assert (c == 2'b00 || c == 2'b01);
            if (vstart_i == '0 && !half_i)
               assert_no_keep_R10: assert (c != 2'b00);
         end
         if (half_i)
            assert_half_keep_R8: assert (keep_cnt >= VLENB / 2);
      end
   end
endmodule

bind vbc_classifier vbc_classifier_chk #(.VLEN(VLEN), .UIDX_W(UIDX_W)) u_chk (
   .vstart_i     (vstart_i),
   .vl_i         (vl_i),
   .sew_i        (sew_i),
   .vm_i         (vm_i),
   .v0_i         (v0_i),
   .uop_idx_i    (uop_idx_i),
   .half_i       (half_i),
   .byte_class_o (byte_class_o)
);

// File: tb/vbc_classifier_test.sv
module vbc_classifier_test;
   localparam int VLEN  = 128;
   localparam int VLENB = 16;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [6:0]   vstart;
   logic [7:0]   vl;
   logic [1:0]   sew;
   logic         vm;
   logic [127:0] v0;
   logic [2:0]   uidx;
   logic         half;
   logic [31:0]  cls;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   vbc_classifier uut (
      .vstart_i(vstart), .vl_i(vl), .sew_i(sew), .vm_i(vm), .v0_i(v0),
      .uop_idx_i(uidx), .half_i(half), .byte_class_o(cls)
   );

   typedef struct packed {
      logic [3:0]   req;
      logic [6:0]   vs;
      logic [7:0]   vl;
      logic [1:0]   sew;
      logic         vm;
      logic [2:0]   uop;
      logic         half;
      logic [127:0] v0;
      logic [31:0]  exp;
   } vec_t;

   // R1 R3 R4 R5 R6 R7 R8: hand-computed vectors
   localparam vec_t TBL [8] = '{
      '{4'd6,  7'd0,  8'd128, 2'd0, 1'b1, 3'd0, 1'b0, 128'h0, 32'hFFFF_FFFF},
      '{4'd5,  7'd0,  8'd0,   2'd0, 1'b1, 3'd0, 1'b0, 128'h0, 32'h5555_5555},
      '{4'd4,  7'd4,  8'd10,  2'd0, 1'b1, 3'd0, 1'b0, 128'h0, 32'h555F_FF00},
      '{4'd2,  7'd0,  8'd1,   2'd3, 1'b1, 3'd0, 1'b0, 128'h0, 32'h5555_FFFF},
      '{4'd3,  7'd0,  8'd6,   2'd2, 1'b1, 3'd1, 1'b0, 128'h0, 32'h5555_FFFF},
      '{4'd8,  7'd0,  8'd128, 2'd0, 1'b1, 3'd1, 1'b1, 128'h0, 32'hFFFF_0000},
      '{4'd7,  7'd0,  8'd128, 2'd1, 1'b0, 3'd0, 1'b0, 128'h5, 32'hAAAA_AFAF},
      '{4'd4,  7'd20, 8'd10,  2'd0, 1'b1, 3'd1, 1'b0, 128'h0, 32'h5555_5500}
   };

   function automatic logic [31:0] model(input int vs_, input int vl_, input int sew_,
                                         input bit vm_, input logic [127:0] m_,
                                         input int u_, input bit h_);
      logic [31:0] r;
      int eb, per, base, e;
      bit skip;
      eb  = 1 << sew_;
      per = VLENB / eb;
      r   = '0;
      for (int b = 0; b < VLENB; b++) begin
         base = h_ ? (u_ / 2) * per : u_ * per;
         e    = base + b / eb;
         skip = h_ && ((b >= VLENB / 2 ? 1 : 0) != u_ % 2);
         if (skip || e < vs_)      r[2*b +: 2] = 2'd0;
         else if (e >= vl_)        r[2*b +: 2] = 2'd1;
         else if (vm_ || m_[e])    r[2*b +: 2] = 2'd3;
         else                      r[2*b +: 2] = 2'd2;
      end
      return r;
   endfunction

   task automatic drive(input int vs_, input int vl_, input int sew_, input bit vm_,
                        input logic [127:0] m_, input int u_, input bit h_);
      @(negedge clk);
      vstart = 7'(vs_); vl = 8'(vl_); sew = 2'(sew_); vm = vm_;
      v0 = m_; uidx = 3'(u_); half = h_;
      #5;
   endtask

   task automatic check(input string tag, input logic [31:0] exp);
      n_cmp++;
      if (cls !== exp) begin
         n_bad++;
         $display("FAIL %s got %h exp %h", tag, cls, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog got timeout exp completion");
      finish_run();
   end

   initial begin
      vstart = '0; vl = '0; sew = '0; vm = 1'b0; v0 = '0; uidx = '0; half = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;

      // R5: idle inputs (length 0) give an all-tail register
      @(negedge clk);
      check("R5 reset state", 32'h5555_5555);

      for (int i = 0; i < 8; i++) begin
         drive(TBL[i].vs, TBL[i].vl, TBL[i].sew, TBL[i].vm, TBL[i].v0, TBL[i].uop, TBL[i].half);
         check($sformatf("R%0d table %0d", TBL[i].req, i), TBL[i].exp);
      end

      // R9: start beyond length, prestart region then tail, no body
      drive(50, 40, 2, 1'b1, '1, 3, 1'b0);
      check("R9 start past length low", 32'h0000_0000);
      drive(50, 40, 0, 1'b0, '1, 4, 1'b0);
      check("R9 start past length high", 32'h5555_5555);
      // R7: full mask, masked op behaves as unmasked
      drive(0, 128, 3, 1'b0, '1, 7, 1'b0);
      check("R7 all-ones mask", 32'hFFFF_FFFF);
      // R8: half mode lower half, upper half kept
      drive(0, 128, 1, 1'b1, '0, 6, 1'b1);
      check("R8 half lower", 32'h0000_FFFF);
      // R4: prestart wins over tail on a boundary
      drive(8, 8, 0, 1'b1, '0, 0, 1'b0);
      check("R4 prestart priority", 32'h5555_0000);

      // R3 R7 R8 R2: sweep all widths, group positions and modes
      for (int s = 0; s < 4; s++)
         for (int u = 0; u < 8; u++)
            for (int h = 0; h < 2; h++)
               for (int m = 0; m < 2; m++)
                  for (int k = 0; k < 3; k++) begin
                     int vs_r, vl_r;
                     logic [127:0] mr;
                     mr   = {$urandom, $urandom, $urandom, $urandom};
                     vs_r = (k == 0) ? 0 : int'($urandom % 128);
                     vl_r = int'($urandom % 129);
                     drive(vs_r, vl_r, s, m[0], mr, u, h[0]);
                     check("R3 R7 R8 sweep", model(vs_r, vl_r, s, m[0], mr, u, h[0]));
                  end

      finish_run();
   end
endmodule